// File: doc/BRIEF.md
# Parallel printer port controller

This block is a byte-wide peripheral in the processor's separate I/O address space. Software reaches it through single-cycle IN/OUT accesses on a 10-bit I/O address bus. It answers at three consecutive addresses. The lowest address holds the byte presented to the printer. The middle address reports whether the printer can take another byte. The highest address holds the strobe control. On the printer side the block drives eight data lines and a strobe, and it receives a busy line from the printer.

A driver sends each byte the same way. It polls the status address until the ready bit reads 1. It writes the byte to the data address. It then writes 1 and then 0 to the control address, which gives the printer one strobe pulse. The block does not time the strobe pulse; software produces it. The byte on the data lines stays unchanged until software writes the data address again.

The busy input is asynchronous, so it passes through a chain of synchronizing flops before it reaches the status register. Read data is combinational from the registers. The read bus is driven only while an I/O-cycle read hits one of the three addresses.

Top module: `lpt_port_ctrl`

## Requirements
- R1: An I/O-cycle write to address 0x378 loads the write byte into the data latch, and `lpt_data` shows it from the next clock.
- R2: `lpt_data` keeps its value through any writes to the control address, through any strobe edge and through any busy activity, until the next write to 0x378.
- R3: Bit 0 of an I/O-cycle write to 0x37A sets `lpt_strobe` from the next clock. Writing 1 and then 0 gives one strobe pulse.
- R4: A read of 0x379 returns 0 in bit 7 (mask 0x80) while the synchronized busy line is high, and 1 while it is low. Bits 6..0 read 0. A change on `lpt_busy` first shows in the status read two clocks after the edge where it is sampled.
- R5: Reads of 0x378 return the last byte written there. Reads of 0x37A return the stored strobe bit in bit 0, and bits 7..1 read 0.
- R6: A write to 0x379 changes no register.
- R7: When `io_cycle` is 0 (a memory cycle), no access has any effect, whatever the address, and `io_rdata_drive` stays 0.
- R8: An access to any address other than 0x378..0x37A changes no register. In that case `io_rdata_drive` is 0 and `io_rdata` is 0x00.
- R9: While `rst_n` is low, `lpt_data` is 0x00, `lpt_strobe` is 0 and the synchronizer stages are cleared, so status reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 10 | Bus address |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| io_wr | input | 1 | Write strobe for this cycle |
| io_rd | input | 1 | Read strobe for this cycle |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, 0 when not driven |
| io_rdata_drive | output | 1 | High when the block drives the read bus |
| lpt_data | output | 8 | Printer data lines |
| lpt_strobe | output | 1 | Printer strobe line |
| lpt_busy | input | 1 | Printer busy, asynchronous |

## Verification
Two things in this block can happen in the same clock: the printer raises or drops busy, and software reads status or writes the strobe. In the bench, the printer model raises busy on the clock after a strobe rising edge and drops it a few clocks later. Meanwhile the driver loop polls status every cycle and rewrites the control address, so busy edges fall in cycles where reads and strobe writes are taking place. A cycle-accurate model of the two-stage delay sets the expected value for every status read, and the data lines are compared on every clock to confirm that the latch stays fixed through those edges.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2,
      SEL_CTRL = 2'd3
   } lpt_sel_e;

   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_CTRL = 2;
   localparam int unsigned PORT_SPAN = 3;
endpackage

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned BASE_ADDR = 'h378
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              io_cycle,
   output lpt_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + OFS_DATA);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + OFS_CTRL);

   initial begin
      assert (BASE_ADDR + PORT_SPAN <= (1 << ADDR_W))
         else $error("port window exceeds I/O space");
   end

   always_comb begin
      sel = SEL_NONE;
      if (io_cycle) begin
         if (addr == A_DATA)      sel = SEL_DATA;
         else if (addr == A_STAT) sel = SEL_STAT;
         else if (addr == A_CTRL) sel = SEL_CTRL;
      end
   end
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   initial begin
      assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RESET_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
   import lpt_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned READY_BIT  = 7,
   parameter int unsigned STROBE_BIT = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  lpt_sel_e          sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy_sync,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_drive,
   output logic [DATA_W-1:0] lpt_data,
   output logic              lpt_strobe
);
   initial begin
      assert (READY_BIT < DATA_W && STROBE_BIT < DATA_W)
         else $error("bit position outside register width");
   end

   logic [DATA_W-1:0] data_q;
   logic              strobe_q;
   logic              wr_data, wr_ctrl;

   assign wr_data = wr && (sel == SEL_DATA);
   assign wr_ctrl = wr && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (wr_data) data_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       strobe_q <= 1'b0;
      else if (wr_ctrl) strobe_q <= wdata[STROBE_BIT];
   end

   always_comb begin
      rdata       = '0;
      rdata_drive = rd && (sel != SEL_NONE);
      if (rd) begin
         unique case (sel)
            SEL_DATA: rdata = data_q;
            SEL_STAT: rdata[READY_BIT]  = ~busy_sync;
            SEL_CTRL: rdata[STROBE_BIT] = strobe_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign lpt_data   = data_q;
   assign lpt_strobe = strobe_q;

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(lpt_data)); // R2
   AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> lpt_data == $past(wdata)); // R1
   AST_STROBE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> lpt_strobe == $past(wdata[STROBE_BIT])); // R3
   AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == SEL_STAT) |-> $countones(rdata) <= 1); // R4
   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_drive |-> rdata == '0); // R8
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BASE_ADDR   = 'h378,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned READY_BIT   = 7,
   parameter int unsigned STROBE_BIT  = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_cycle,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rdata_drive,
   output logic [DATA_W-1:0] lpt_data,
   output logic              lpt_strobe,
   input  logic              lpt_busy
);
   lpt_sel_e sel;
   logic     busy_sync;

   lpt_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr     (io_addr),
      .io_cycle (io_cycle),
      .sel      (sel)
   );

   lpt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (lpt_busy),
      .sync_out (busy_sync)
   );

   lpt_regs #(.DATA_W(DATA_W), .READY_BIT(READY_BIT), .STROBE_BIT(STROBE_BIT)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (sel),
      .wr          (io_wr),
      .rd          (io_rd),
      .wdata       (io_wdata),
      .busy_sync   (busy_sync),
      .rdata       (io_rdata),
      .rdata_drive (io_rdata_drive),
      .lpt_data    (lpt_data),
      .lpt_strobe  (lpt_strobe)
   );

   AST_MEM_CYCLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cycle |-> !io_rdata_drive); // R7
   AST_MEM_CYCLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cycle |=> $stable(lpt_data) && $stable(lpt_strobe)); // R7
endmodule

// File: tb/lpt_port_ctrl_bench.sv
module lpt_port_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] io_addr = '0;
   logic       io_cycle = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic       io_rdata_drive;
   logic [7:0] lpt_data;
   logic       lpt_strobe;
   logic       lpt_busy = 1'b0;

   always #5 clk = ~clk;

   lpt_port_ctrl u_lpt_port_ctrl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_cycle(io_cycle),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_rdata_drive(io_rdata_drive), .lpt_data(lpt_data),
      .lpt_strobe(lpt_strobe), .lpt_busy(lpt_busy)
   );

   int    checks = 0, failures = 0;
   bit    finished = 0;
   string cur_req = "R9";

   // reference state
   int m_data = 0, m_strobe = 0, m_s1 = 0, m_s2 = 0;
   // printer model
   int prn_cnt = 0, force_busy = 0, prev_strobe = 0;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cycle(input int addr, input int iocyc, input int wr,
                        input int rd, input int wd);
      int exp_rd, exp_drv;
      @(negedge clk);
      lpt_busy = (prn_cnt > 0) || (force_busy != 0);
      if (prn_cnt > 0) prn_cnt--;
      io_addr = addr[9:0]; io_cycle = iocyc[0]; io_wr = wr[0]; io_rd = rd[0];
      io_wdata = wd[7:0];
      #1;
      exp_rd = 0; exp_drv = 0;
      if (rd != 0 && iocyc != 0) begin
         if (addr == 'h378)      begin exp_drv = 1; exp_rd = m_data; end
         else if (addr == 'h379) begin exp_drv = 1; exp_rd = (m_s2 != 0) ? 'h00 : 'h80; end
         else if (addr == 'h37A) begin exp_drv = 1; exp_rd = m_strobe; end
      end
      check(cur_req, "rdata", int'(io_rdata), exp_rd);
      check(cur_req, "rdata_drive", int'(io_rdata_drive), exp_drv);
      check(cur_req, "lpt_data", int'(lpt_data), m_data);
      check(cur_req, "lpt_strobe", int'(lpt_strobe), m_strobe);
      @(posedge clk);
      m_s2 = m_s1;
      m_s1 = lpt_busy ? 1 : 0;
      if (wr != 0 && iocyc != 0) begin
         if (addr == 'h378) m_data = wd & 'hFF;
         if (addr == 'h37A) m_strobe = wd & 1;
      end
      // printer: rising strobe seen after this edge arms busy
      #1;
      if (lpt_strobe && prev_strobe == 0) prn_cnt = 6;
      prev_strobe = lpt_strobe ? 1 : 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle('h000, 0, 0, 0, 0);
   endtask

   task automatic send_byte(input int b);
      int guard = 0;
      cur_req = "R4";
      cycle('h379, 1, 0, 1, 0);
      while (io_rdata[7] == 1'b0 && guard < 50) begin
         cycle('h379, 1, 0, 1, 0);
         guard++;
      end
      cur_req = "R1"; cycle('h378, 1, 1, 0, b);
      cur_req = "R3"; cycle('h37A, 1, 1, 0, 1);
      cur_req = "R2"; cycle('h37A, 1, 1, 1, 0);
   endtask

   initial begin
      // R9: reset state
      cur_req = "R9";
      repeat (3) begin
         @(negedge clk); #1;
         check("R9", "lpt_data", int'(lpt_data), 0);
         check("R9", "lpt_strobe", int'(lpt_strobe), 0);
         check("R9", "rdata_drive", int'(io_rdata_drive), 0);
      end
      rst_n = 1'b1;
      cur_req = "R9"; cycle('h379, 1, 0, 1, 0);

      // R4: busy through synchronizer, read each cycle across edges
      cur_req = "R4";
      force_busy = 1;
      for (int i = 0; i < 4; i++) cycle('h379, 1, 0, 1, 0);
      force_busy = 0;
      for (int i = 0; i < 4; i++) cycle('h379, 1, 0, 1, 0);

      // R1 / R5: data write and readback
      cur_req = "R1"; cycle('h378, 1, 1, 0, 'hA5);
      cur_req = "R5"; cycle('h378, 1, 0, 1, 0);
      cur_req = "R1"; cycle('h378, 1, 1, 1, 'h3C);
      cur_req = "R5"; cycle('h378, 1, 0, 1, 0);

      // R3 / R5: strobe control, unused bits read 0
      cur_req = "R3"; cycle('h37A, 1, 1, 0, 'hFF);
      cur_req = "R5"; cycle('h37A, 1, 0, 1, 0);
      cur_req = "R3"; cycle('h37A, 1, 1, 0, 'hFE);
      cur_req = "R5"; cycle('h37A, 1, 0, 1, 0);

      // R2: strobe and busy activity with latch held; concurrent polling
      cur_req = "R2";
      send_byte('h48);
      send_byte('h69);
      send_byte('h00);
      send_byte('hFF);
      cur_req = "R2"; idle(8);

      // R6: writes to status ignored
      cur_req = "R6"; cycle('h379, 1, 1, 0, 'h55);
      cycle('h379, 1, 1, 0, 'hFF);
      cycle('h378, 1, 0, 1, 0);
      cycle('h37A, 1, 0, 1, 0);

      // R7: memory cycles at the port addresses
      cur_req = "R7"; cycle('h378, 0, 1, 0, 'h99);
      cycle('h37A, 0, 1, 0, 'h01);
      cycle('h378, 0, 0, 1, 0);
      cycle('h379, 0, 0, 1, 0);
      cycle('h378, 1, 0, 1, 0);

      // R8: neighbouring and distant addresses
      cur_req = "R8";
      cycle('h37B, 1, 1, 1, 'h77);
      cycle('h377, 1, 1, 1, 'h01);
      cycle('h000, 1, 1, 1, 'h12);
      cycle('h3FF, 1, 1, 1, 'h34);
      cycle('h178, 1, 1, 1, 'h56);
      cycle('h378, 1, 0, 1, 0);
      cycle('h37A, 1, 0, 1, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule